// File: doc/BRIEF.md
# Control-Instruction Execution Unit

This block executes the control and register-move group of a 13-bit instruction word for a small 8-bit accumulator microcontroller. A wider core hands it the current instruction, the accumulator value, the carry and digit-carry flags, the control register, the read data of the I/O control register, and the bank bits of the bank-select register. Within the same cycle it drives write strobes and data toward the register file, the accumulator, the control register and the I/O control registers. It also produces flag updates for zero, carry, digit carry and the timeout/power-down pair, and issues watchdog-clear and sleep requests.

The block holds the 10-bit program counter, the global interrupt enable and an 8-level circular return stack. Each executed instruction advances the PC by one, except table jumps and returns. Table jumps add the accumulator to the low PC byte and leave the page bits alone. Returns pop the stack, and the interrupt-return form also enables interrupts. When the wider core executes a subroutine call, it signals this with a call request carrying the target address; the block then pushes the return address.

Any instruction word outside this group raises `unhandled` so that the wider core can execute it elsewhere. The PC still advances past such a word.

Top module: `ctl_exec`

## Requirements
- R1: After reset `pc` is 0 and `gie` is 0. While `instr_vld` and `call_req` are both low, every write strobe, flag strobe and request output is low, and `pc` and `gie` hold.
- R2: 0x0001 (decimal adjust) writes the accumulator and changes only C. It first adds 0x06 if the low nibble exceeds 9 or `flag_dc` is 1. It then adds 0x60 if the resulting high nibble exceeds 9 or `flag_c` is 1. C is written 1 exactly when the second addition happens.
- R3: 0x0000 has no effect. 0x0002 asserts `cont_we`. 0x0003 asserts `wdt_clr` and `sleep_req` and writes T=1, P=0. 0x0004 asserts `wdt_clr` only and writes T=1, P=1. None of the five changes Z, C or DC, except as R2 states for 0x0001.
- R4: Words 0x0005–0x000F assert `ioc_we`, and words 0x0015–0x001F load the accumulator from `ioc_rdata`. In both, `ioc_sel` equals instruction bits 3:0, and no flag changes.
- R5: 0x0010 sets `gie` and 0x0011 clears it. 0x0012 pops the stack into `pc` with `gie` unchanged. 0x0013 pops the stack into `pc` and sets `gie`. 0x0014 loads the accumulator from `cont_q`. None of these words updates a flag.
- R6: 0x0020 sets `pc[7:0]` to `pc[7:0]+acc` modulo 256 and keeps `pc[9:8]`. It writes Z (the new low byte is zero), C (carry out of bit 7) and DC (carry out of bit 3).
- R7: Words 0x0040–0x007F write `acc` to register address {`bank_sel`, instruction bits 5:0} and update no flag.
- R8: 0x0080 writes 0 to the accumulator and Z=1. Words 0x00C0–0x00FF write 0 to register {`bank_sel`, bits 5:0} and Z=1.
- R9: Every other word (0x0021–0x003F, 0x0081–0x00BF, 0x0100–0x1FFF) raises `unhandled`, asserts no write, flag or request strobe, and advances `pc` by one.
- R10: Each executed word other than 0x0012, 0x0013 and 0x0020 advances `pc` by one, wrapping at 10 bits.
- R11: `call_req` pushes `pc+1`, loads `call_addr` into `pc`, and suppresses the instruction presented in that cycle. The stack is circular with 8 entries, so a ninth push overwrites the oldest entry, and popping more entries than were pushed reads around the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_vld | input | 1 | Instruction word executes this cycle |
| instr | input | 13 | Instruction word |
| acc | input | 8 | Current accumulator |
| flag_c | input | 1 | Current carry flag |
| flag_dc | input | 1 | Current digit-carry flag |
| cont_q | input | 8 | Current control register |
| ioc_rdata | input | 8 | Read data of the selected I/O control register |
| bank_sel | input | 2 | Bank bits of the bank-select register |
| call_req | input | 1 | Wider core executes a subroutine call |
| call_addr | input | 10 | Call target |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 8 | Accumulator write data |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 8 | Register-file write address {bank, field} |
| rf_wdata | output | 8 | Register-file write data |
| cont_we | output | 1 | Control register loads `acc` |
| ioc_we | output | 1 | Selected I/O control register loads `acc` |
| ioc_sel | output | 4 | I/O control register select |
| z_we | output | 1 | Zero flag write strobe |
| z_val | output | 1 | Zero flag value |
| c_we | output | 1 | Carry flag write strobe |
| c_val | output | 1 | Carry flag value |
| dc_we | output | 1 | Digit-carry flag write strobe |
| dc_val | output | 1 | Digit-carry flag value |
| tp_we | output | 1 | Timeout/power-down flag write strobe |
| t_val | output | 1 | Timeout flag value |
| p_val | output | 1 | Power-down flag value |
| wdt_clr | output | 1 | Watchdog clear request |
| sleep_req | output | 1 | Oscillator stop request |
| gie | output | 1 | Global interrupt enable |
| pc | output | 10 | Program counter |
| unhandled | output | 1 | Instruction outside this group |

## Verification
The bench builds the block with its default parameters: a 10-bit PC, an 8-entry stack and 8-bit data. These values are small enough that all 8192 instruction words can be swept, each with an accumulator, flags and bank derived from the word. The decimal adjust is swept over every accumulator value under all four carry and digit-carry combinations. The table jump is swept over every accumulator value from a moving PC, so that page wrap-around and every carry case occur. Nine calls followed by nine returns reach past the stack depth, which exercises the overwrite and ring-around behaviour.

// File: rtl/ctl_exec.sv
module ctl_exec #(
  parameter int PC_W  = 10,
  parameter int STK_D = 8,
  parameter int DW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_vld,
  input  logic [12:0]     instr,
  input  logic [DW-1:0]   acc,
  input  logic            flag_c,
  input  logic            flag_dc,
  input  logic [DW-1:0]   cont_q,
  input  logic [DW-1:0]   ioc_rdata,
  input  logic [1:0]      bank_sel,
  input  logic            call_req,
  input  logic [PC_W-1:0] call_addr,
  output logic            acc_we,
  output logic [DW-1:0]   acc_wdata,
  output logic            rf_we,
  output logic [7:0]      rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            cont_we,
  output logic            ioc_we,
  output logic [3:0]      ioc_sel,
  output logic            z_we,
  output logic            z_val,
  output logic            c_we,
  output logic            c_val,
  output logic            dc_we,
  output logic            dc_val,
  output logic            tp_we,
  output logic            t_val,
  output logic            p_val,
  output logic            wdt_clr,
  output logic            sleep_req,
  output logic            gie,
  output logic [PC_W-1:0] pc,
  output logic            unhandled
);
  localparam int SP_W = $clog2(STK_D);

  wire go = instr_vld && !call_req;

  wire is_daa   = instr == 13'h0001;
  wire is_contw = instr == 13'h0002;
  wire is_slep  = instr == 13'h0003;
  wire is_wdtc  = instr == 13'h0004;
  wire is_iow   = instr[12:4] == 9'h000 && instr[3:0] > 4'd4;
  wire is_eni   = instr == 13'h0010;
  wire is_disi  = instr == 13'h0011;
  wire is_ret   = instr == 13'h0012;
  wire is_reti  = instr == 13'h0013;
  wire is_contr = instr == 13'h0014;
  wire is_ior   = instr[12:4] == 9'h001 && instr[3:0] > 4'd4;
  wire is_tbl   = instr == 13'h0020;
  wire is_mov   = instr[12:6] == 7'h01;
  wire is_clra  = instr == 13'h0080;
  wire is_clr   = instr[12:6] == 7'h03;

  wire known = instr[12:4] == 9'h000 || instr[12:4] == 9'h001 || is_tbl ||
               is_mov || is_clra || is_clr;

  logic [DW-1:0] daa_a, daa_r;
  logic          daa_hi;
  always_comb begin
    daa_a  = acc + ((acc[3:0] > 4'd9 || flag_dc) ? 8'h06 : 8'h00);
    daa_hi = daa_a[7:4] > 4'd9 || flag_c;
    daa_r  = daa_a + (daa_hi ? 8'h60 : 8'h00);
  end

  wire [8:0] tbl_sum = {1'b0, acc} + {1'b0, pc[7:0]};
  wire [4:0] tbl_nib = {1'b0, acc[3:0]} + {1'b0, pc[3:0]};
  wire [PC_W-1:0] pc_inc = pc + 1'b1;

  assign acc_we    = go && (is_daa || is_ior || is_contr || is_clra);
  assign acc_wdata = is_daa ? daa_r : is_ior ? ioc_rdata : is_contr ? cont_q : '0;
  assign rf_we     = go && (is_mov || is_clr);
  assign rf_waddr  = {bank_sel, instr[5:0]};
  assign rf_wdata  = is_mov ? acc : '0;
  assign cont_we   = go && is_contw;
  assign ioc_we    = go && is_iow;
  assign ioc_sel   = instr[3:0];
  assign z_we      = go && (is_tbl || is_clra || is_clr);
  assign z_val     = is_tbl ? (tbl_sum[7:0] == 8'h00) : 1'b1;
  assign c_we      = go && (is_daa || is_tbl);
  assign c_val     = is_daa ? daa_hi : tbl_sum[8];
  assign dc_we     = go && is_tbl;
  assign dc_val    = tbl_nib[4];
  assign tp_we     = go && (is_slep || is_wdtc);
  assign t_val     = 1'b1;
  assign p_val     = is_wdtc;
  assign wdt_clr   = tp_we;
  assign sleep_req = go && is_slep;
  assign unhandled = go && !known;

  logic [PC_W-1:0] stk [STK_D];
  logic [SP_W-1:0] sp;
  wire  [SP_W-1:0] sp_dn = sp - 1'b1;

  always_ff @(posedge clk)
    if (call_req) stk[sp] <= pc_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      sp  <= '0;
      gie <= 1'b0;
    end else if (call_req) begin
      pc <= call_addr;
      sp <= sp + 1'b1;
    end else if (instr_vld) begin
      if (is_ret || is_reti) begin
        pc <= stk[sp_dn];
        sp <= sp_dn;
      end else if (is_tbl) begin
        pc <= {pc[PC_W-1:8], tbl_sum[7:0]};
      end else begin
        pc <= pc_inc;
      end
      if (is_eni || is_reti) gie <= 1'b1;
      else if (is_disi)      gie <= 1'b0;
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_vld && !call_req) |=> ($stable(pc) && $stable(gie)));
  // R9
  unhandled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled |-> !(acc_we || rf_we || cont_we || ioc_we || z_we || c_we || dc_we || tp_we || sleep_req));
  // R9
  unhandled_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled |=> pc == $past(pc_inc));
  // R6
  tbl_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && is_tbl) |=> pc[PC_W-1:8] == $past(pc[PC_W-1:8]));
  // R5
  reti_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && is_reti) |=> gie);
  // R5
  disi_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && is_disi) |=> !gie);
  // R11
  call_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> pc == $past(call_addr));
  // R7
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_we, rf_we, cont_we, ioc_we}));
endmodule

// File: tb/sim_ctl_exec.sv
`timescale 1ns/1ps
module sim_ctl_exec;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic instr_vld = 0, flag_c = 0, flag_dc = 0, call_req = 0;
  logic [12:0] instr = '0;
  logic [7:0] acc = '0, cont_q = '0, ioc_rdata = '0;
  logic [1:0] bank_sel = '0;
  logic [9:0] call_addr = '0;
  logic acc_we, rf_we, cont_we, ioc_we, z_we, z_val, c_we, c_val, dc_we, dc_val;
  logic tp_we, t_val, p_val, wdt_clr, sleep_req, gie, unhandled;
  logic [7:0] acc_wdata, rf_waddr, rf_wdata;
  logic [3:0] ioc_sel;
  logic [9:0] pc;

  ctl_exec u0 (.*);

  int checks = 0, errors = 0;
  logic [9:0] epc = '0, estk [8];
  int esp = 0;
  logic egie = 0;
  string ptag = "R1";

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic v, input logic cr, input logic [12:0] w);
    if (cr) return "R11";
    if (!v) return "R1";
    if (w == 13'h1) return "R2";
    if (w <= 13'h4) return "R3";
    if (w <= 13'hF || (w >= 13'h15 && w <= 13'h1F)) return "R4";
    if (w <= 13'h14) return "R5";
    if (w == 13'h20) return "R6";
    if (w >= 13'h40 && w <= 13'h7F) return "R7";
    if (w == 13'h80 || (w >= 13'hC0 && w <= 13'hFF)) return "R8";
    return "R9";
  endfunction

  function automatic logic [63:0] actv();
    return {acc_we, acc_we ? acc_wdata : 8'h0, rf_we, rf_we ? rf_waddr : 8'h0,
            rf_we ? rf_wdata : 8'h0, cont_we, ioc_we, ioc_we ? ioc_sel : 4'h0,
            z_we, z_we & z_val, c_we, c_we & c_val, dc_we, dc_we & dc_val,
            tp_we, tp_we & t_val, tp_we & p_val, wdt_clr, sleep_req, unhandled};
  endfunction

  function automatic logic [63:0] expv(input logic v, input logic cr, input logic [12:0] w,
      input logic [7:0] a, input logic c, input logic dc, input logic [7:0] ct,
      input logic [7:0] iod, input logic [1:0] bk, input logic [9:0] p);
    logic aw = 0, rw = 0, cw = 0, iw = 0, zw = 0, zv = 0, cyw = 0, cyv = 0;
    logic dw = 0, dv = 0, tw = 0, pv = 0, wc = 0, sl = 0, un = 0;
    logic [7:0] ad = 0, ra = 0, rd = 0;
    logic [3:0] is = 0;
    int t, s;
    string g;
    g = tag_of(v, cr, w);
    if (g == "R2") begin
      t = a;
      if ((a % 16) > 9 || dc) t = (t + 6) % 256;
      cyv = (t / 16) > 9 || c;
      if (cyv) t = (t + 96) % 256;
      aw = 1; ad = t[7:0]; cyw = 1;
    end else if (g == "R3") begin
      cw = (w == 2); tw = (w >= 3); wc = tw; sl = (w == 3); pv = (w == 4);
    end else if (g == "R4") begin
      if (w[4]) begin aw = 1; ad = iod; end else begin iw = 1; is = w[3:0]; end
    end else if (g == "R5") begin
      if (w == 13'h14) begin aw = 1; ad = ct; end
    end else if (g == "R6") begin
      s = a + p[7:0];
      zw = 1; zv = (s % 256) == 0; cyw = 1; cyv = s > 255;
      dw = 1; dv = (a % 16 + p % 16) > 15;
    end else if (g == "R7") begin
      rw = 1; ra = {bk, w[5:0]}; rd = a;
    end else if (g == "R8") begin
      zw = 1; zv = 1;
      if (w == 13'h80) aw = 1; else begin rw = 1; ra = {bk, w[5:0]}; end
    end else if (g == "R9") un = 1;
    return {aw, ad, rw, ra, rd, cw, iw, is, zw, zv, cyw, cyv, dw, dv,
            tw, tw, pv, wc, sl, un};
  endfunction

  task automatic step(input logic v, input logic [12:0] w, input logic [7:0] a,
      input logic c, input logic dc, input logic [7:0] ct, input logic [7:0] iod,
      input logic [1:0] bk, input logic cr, input logic [9:0] ca);
    string g;
    @(negedge clk);
    chk({ptag, " pc"}, {54'h0, pc}, {54'h0, epc});
    chk({ptag, " gie"}, {63'h0, gie}, {63'h0, egie});
    instr_vld = v; instr = w; acc = a; flag_c = c; flag_dc = dc; cont_q = ct;
    ioc_rdata = iod; bank_sel = bk; call_req = cr; call_addr = ca;
    #1;
    g = tag_of(v, cr, w);
    chk(g, actv(), expv(v, cr, w, a, c, dc, ct, iod, bk, epc));
    @(posedge clk);
    if (cr) begin
      estk[esp] = epc + 10'd1; esp = (esp + 1) % 8; epc = ca;
    end else if (v) begin
      if (w == 13'h12 || w == 13'h13) begin
        esp = (esp + 7) % 8; epc = estk[esp];
      end else if (w == 13'h20) epc = {epc[9:8], 8'(epc[7:0] + a)};
      else epc = epc + 10'd1;
      if (w == 13'h10 || w == 13'h13) egie = 1;
      if (w == 13'h11) egie = 0;
    end
    ptag = g;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state and idle cycles
    step(0, 13'h80, 8'h11, 0, 0, 0, 0, 0, 0, 0);
    step(0, 13'h13, 8'h22, 1, 1, 0, 0, 0, 0, 0);
    // R11 call overrides the presented instruction
    step(1, 13'h80, 8'h33, 0, 0, 0, 0, 0, 1, 10'h155);
    step(0, 13'h0, 8'h0, 0, 0, 0, 0, 0, 1, 10'h2F0);
    // R2..R10 exhaustive word sweep
    for (int w = 0; w < 8192; w++) begin
      logic [7:0] a = 8'(w) ^ 8'h5A;
      step(1, 13'(w), a, w[0], w[1], ~a, 8'(a + 8'd3), 2'(w >> 8), 0, 0);
      if (w % 97 == 0) step(0, 13'h12, a, 0, 0, 0, 0, 0, 0, 0);
    end
    // R2 decimal adjust sweep
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 4; f++)
        step(1, 13'h1, 8'(a), f[0], f[1], 0, 0, 0, 0, 0);
    // R6 table jump sweep with page wrap
    step(1, 13'h0, 0, 0, 0, 0, 0, 0, 1, 10'h3F0);
    for (int a = 0; a < 256; a++) begin
      step(1, 13'h20, 8'(a), 0, 0, 0, 0, 0, 0, 0);
      step(1, 13'h0, 0, 0, 0, 0, 0, 0, 0, 0);
    end
    // R11 ring overwrite: nine calls, nine returns
    for (int k = 0; k < 9; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 1, 10'(k * 37 + 5));
    for (int k = 0; k < 9; k++) step(1, (k % 2) ? 13'h13 : 13'h12, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 13'h11, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule